// File: doc/BRIEF.md
# CAN Data Frame Receiver with CRC Acceptance

This block listens to one serial receive line of a CAN bus and turns standard-format data and remote frames into parallel fields. It first waits until the line has been recessive for a full idle interval. It then treats the next dominant level as the start of a frame and times every following bit from that edge, sampling each bit at the middle of its period. The identifier, the remote-request flag, the data length code and up to eight data bytes are shifted into holding registers. A 15-bit CRC runs over the frame as the bits arrive.

When the received CRC sequence equals the locally computed one and the delimiter after it is recessive, the block drives a dominant acknowledge for the whole acknowledge slot. It then checks that the acknowledge delimiter and the end-of-frame bits stay recessive. If they do, it publishes the captured fields together with a one-clock valid strobe. Any frame that fails a check is dropped without touching the published fields. The receiver then waits for a fresh idle interval. Bit destuffing, error frames and extended identifiers are not handled. The line is brought into the clock domain through a short synchroniser, so every response is delayed by its depth.

Top module: `canrx_frame`

## Requirements
- R1: After reset, `ack_drv_o` and `frame_valid_o` are 0 and `id_o`, `rtr_o`, `dlc_o`, `data_o` are all zero.
- R2: A frame starts only on a dominant level that follows at least IDLE_BITS bit times (default 11) of continuous recessive line. A dominant level seen earlier gives neither an acknowledge nor a valid strobe.
- R3: Each bit is sampled CLKS_PER_BIT/2 clocks into its period, with periods counted from the detected falling edge. If the start bit reads recessive at its sample point, the edge is treated as a glitch and no frame is received.
- R4: The bit order is fixed: start bit (dominant), 11-bit identifier MSB first, remote flag, two reserved control bits (value ignored), 4-bit length code MSB first, data bits MSB first, 15-bit CRC MSB first, CRC delimiter, acknowledge slot, acknowledge delimiter, 7 end-of-frame bits. A frame with 8 data bytes is 108 bits long.
- R5: The data field holds 8*min(DLC,8) bits. A length code of 9 to 15 carries 64 data bits, and `dlc_o` reports the code exactly as received.
- R6: A frame whose remote flag is recessive (1) has no data field. It is delivered with `data_o` equal to zero.
- R7: The CRC uses the generator 0x4599 with a zero start value and covers the start bit through the last data bit. When it matches the received sequence and the CRC delimiter is recessive, `ack_drv_o` is 1 for exactly CLKS_PER_BIT clocks. These clocks start at the beginning of the acknowledge slot as seen after the synchroniser.
- R8: On a CRC mismatch, `ack_drv_o` stays 0, no valid strobe is given, and the output fields keep their previous values.
- R9: A dominant CRC delimiter drops the frame with no acknowledge and no valid strobe.
- R10: A dominant acknowledge delimiter or end-of-frame bit drops the frame (no valid strobe) even though the acknowledge was already given.
- R11: `frame_valid_o` is a single-clock pulse in the clock after the sample point of the last end-of-frame bit. The output fields change only in that same clock. The first data byte is placed in `data_o[63:56]`, and bytes not carried are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Bus receive level, 0 = dominant |
| ack_drv_o | output | 1 | 1 = drive the bus dominant (acknowledge) |
| frame_valid_o | output | 1 | One-clock strobe for a good frame |
| id_o | output | 11 | Identifier of the last good frame |
| rtr_o | output | 1 | Remote flag of the last good frame |
| dlc_o | output | 4 | Length code of the last good frame |
| data_o | output | 64 | Data bytes, first byte in the top bits |

## Verification
The bench goes after the length-code corners: zero bytes, a partial payload, an oversized code and a remote frame. A design that sized the data field wrongly would misplace every CRC bit after it, so it would never acknowledge and never validate. Corrupted CRC, a dominant delimiter and a dominant end-of-frame bit are each sent. A receiver that checked too little would acknowledge or validate frames it must drop, and one that leaked the discarded capture would show changed fields. A start without a preceding idle interval and a two-clock dominant glitch test the start logic. The acknowledge window and the valid strobe are compared clock by clock, so a one-clock slip in bit timing fails.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  localparam int unsigned CRC_W        = 15;
  localparam logic [14:0] CRC_GEN      = 15'h4599;
  localparam int unsigned ID_W         = 11;
  localparam int unsigned DLC_W        = 4;
  localparam int unsigned MAX_BYTES    = 8;
  localparam int unsigned DATA_W       = MAX_BYTES * 8;
  localparam int unsigned FRAME_BITS   = 44 + DATA_W;
  localparam int unsigned POS_W        = $clog2(FRAME_BITS + 1);
  localparam int unsigned NB_W         = $clog2(DATA_W + 1);

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rx_state_e;

  typedef enum logic [3:0] {
    SEG_SOF,
    SEG_ID,
    SEG_RTR,
    SEG_RSV,
    SEG_DLC,
    SEG_DATA,
    SEG_CRC,
    SEG_CRC_DELIM,
    SEG_ACK_SLOT,
    SEG_ACK_DELIM,
    SEG_EOF,
    SEG_DONE
  } seg_e;

  // one step of the serial CRC register
  function automatic logic [14:0] crc15_step(logic [14:0] c, logic b);
    logic fb;
    fb = b ^ c[14];
    return fb ? ({c[13:0], 1'b0} ^ CRC_GEN) : {c[13:0], 1'b0};
  endfunction

  // number of data bits carried by a frame
  function automatic logic [NB_W-1:0] data_bits_of(logic [3:0] dlc, logic rtr);
    if (rtr) return '0;
    if (dlc >= 4'd8) return NB_W'(DATA_W);
    return NB_W'({dlc[2:0], 3'b000});
  endfunction

  // index of the last end-of-frame bit
  function automatic logic [7:0] eof_last_pos(logic [NB_W-1:0] n);
    return 8'd43 + 8'(n);
  endfunction

  // which field a bit index belongs to
  function automatic seg_e seg_of(logic [POS_W-1:0] pos, logic [NB_W-1:0] n);
    logic [7:0] p;
    logic [7:0] d;
    p = 8'(pos);
    d = 8'(n);
    if (p == 8'd0)                 return SEG_SOF;
    if (p < 8'd12)                 return SEG_ID;
    if (p == 8'd12)                return SEG_RTR;
    if (p < 8'd15)                 return SEG_RSV;
    if (p < 8'd19)                 return SEG_DLC;
    if (p < 8'd19 + d)             return SEG_DATA;
    if (p < 8'd34 + d)             return SEG_CRC;
    if (p == 8'd34 + d)            return SEG_CRC_DELIM;
    if (p == 8'd35 + d)            return SEG_ACK_SLOT;
    if (p == 8'd36 + d)            return SEG_ACK_DELIM;
    if (p <= eof_last_pos(n))      return SEG_EOF;
    return SEG_DONE;
  endfunction

endpackage

// File: rtl/canrx_sync.sv
module canrx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/canrx_idle_det.sv
module canrx_idle_det #(
  parameter int unsigned LIMIT = 88
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  output logic idle_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (!rx_s)                 cnt <= '0;
    else if (cnt != CW'(LIMIT))     cnt <= cnt + 1'b1;
  end

  assign idle_o = (cnt == CW'(LIMIT));
endmodule

// File: rtl/canrx_bit_timer.sv
module canrx_bit_timer #(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic mid_o,
  output logic end_o
);
  localparam int unsigned PW   = $clog2(CLKS_PER_BIT);
  localparam int unsigned HALF = CLKS_PER_BIT / 2;
  logic [PW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 phase <= '0;
    else if (start_i)                           phase <= PW'(1);
    else if (run_i) begin
      if (phase == PW'(CLKS_PER_BIT - 1))       phase <= '0;
      else                                      phase <= phase + 1'b1;
    end
  end

  assign mid_o = run_i && (phase == PW'(HALF));
  assign end_o = run_i && (phase == PW'(CLKS_PER_BIT - 1));
endmodule

// File: rtl/canrx_crc15.sv
module canrx_crc15
  import canrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [14:0] crc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_o <= '0;
    else if (clear_i) crc_o <= '0;
    else if (en_i)    crc_o <= crc15_step(crc_o, bit_i);
  end
endmodule

// File: rtl/canrx_frame.sv
module canrx_frame
  import canrx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned IDLE_BITS    = 11,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_i,
  output logic        ack_drv_o,
  output logic        frame_valid_o,
  output logic [10:0] id_o,
  output logic        rtr_o,
  output logic [3:0]  dlc_o,
  output logic [63:0] data_o
);
  localparam int unsigned IDLE_CLKS = IDLE_BITS * CLKS_PER_BIT;

  // named internal events
  logic             rx_s;
  logic             rx_q;
  logic             bus_idle;
  logic             fall;
  logic             sof_start;
  logic             tick;
  logic             bit_end;
  logic             crc_en;
  logic             crc_match;
  logic             last_eof;
  rx_state_e        state;
  seg_e             seg;
  logic [POS_W-1:0] pos;
  logic [NB_W-1:0]  nbits;
  logic [14:0]      crc_calc;
  logic [14:0]      crc_rx;
  logic [10:0]      id_sh;
  logic             rtr_r;
  logic [3:0]       dlc_sh;
  logic [63:0]      data_sh;
  logic             ack_pend;

  canrx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  canrx_idle_det #(.LIMIT(IDLE_CLKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .idle_o(bus_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx_s;
  end

  assign fall      = rx_q && !rx_s;
  assign sof_start = (state == ST_HUNT) && bus_idle && fall;

  canrx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(sof_start),
    .run_i(state == ST_FRAME), .mid_o(tick), .end_o(bit_end)
  );

  assign nbits    = data_bits_of(dlc_sh, rtr_r);
  assign seg      = seg_of(pos, nbits);
  assign last_eof = (8'(pos) == eof_last_pos(nbits));
  assign crc_en   = tick && (seg == SEG_SOF || seg == SEG_ID || seg == SEG_RTR ||
                             seg == SEG_RSV || seg == SEG_DLC || seg == SEG_DATA);

  canrx_crc15 u_crc (
    .clk(clk), .rst_n(rst_n), .clear_i(sof_start), .en_i(crc_en),
    .bit_i(rx_s), .crc_o(crc_calc)
  );

  assign crc_match = (crc_calc == crc_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_HUNT;
      pos           <= '0;
      id_sh         <= '0;
      rtr_r         <= 1'b0;
      dlc_sh        <= '0;
      data_sh       <= '0;
      crc_rx        <= '0;
      ack_pend      <= 1'b0;
      ack_drv_o     <= 1'b0;
      frame_valid_o <= 1'b0;
      id_o          <= '0;
      rtr_o         <= 1'b0;
      dlc_o         <= '0;
      data_o        <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      case (state)
        ST_HUNT: begin
          ack_drv_o <= 1'b0;
          ack_pend  <= 1'b0;
          if (sof_start) begin
            state   <= ST_FRAME;
            pos     <= '0;
            id_sh   <= '0;
            rtr_r   <= 1'b0;
            dlc_sh  <= '0;
            data_sh <= '0;
            crc_rx  <= '0;
          end
        end
        default: begin
          if (bit_end) begin
            if (ack_pend) begin
              ack_drv_o <= 1'b1;
              ack_pend  <= 1'b0;
            end else begin
              ack_drv_o <= 1'b0;
            end
          end
          if (tick) begin
            pos <= pos + 1'b1;
            case (seg)
              SEG_SOF:   if (rx_s) state <= ST_HUNT;
              SEG_ID:    id_sh   <= {id_sh[9:0], rx_s};
              SEG_RTR:   rtr_r   <= rx_s;
              SEG_DLC:   dlc_sh  <= {dlc_sh[2:0], rx_s};
              SEG_DATA:  data_sh <= {data_sh[62:0], rx_s};
              SEG_CRC:   crc_rx  <= {crc_rx[13:0], rx_s};
              SEG_CRC_DELIM: begin
                if (!rx_s || !crc_match) state    <= ST_HUNT;
                else                     ack_pend <= 1'b1;
              end
              SEG_ACK_DELIM: if (!rx_s) state <= ST_HUNT;
              SEG_EOF: begin
                if (!rx_s) begin
                  state <= ST_HUNT;
                end else if (last_eof) begin
                  state         <= ST_HUNT;
                  frame_valid_o <= 1'b1;
                  id_o          <= id_sh;
                  rtr_o         <= rtr_r;
                  dlc_o         <= dlc_sh;
                  data_o        <= data_sh << (NB_W'(DATA_W) - nbits);
                end
              end
              SEG_DONE:  state <= ST_HUNT;
              default:   ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/canrx_chk.sv
module canrx_chk
  import canrx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input logic      clk,
  input logic      rst_n,
  input logic      rx_s,
  input logic      bus_idle,
  input logic      tick,
  input rx_state_e state,
  input seg_e      seg,
  input logic      ack_drv_o,
  input logic      frame_valid_o
);
  int   ack_len;
  int   gap;
  logic seen_tick;
  logic acked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_len   <= 0;
      gap       <= 0;
      seen_tick <= 1'b0;
      acked     <= 1'b0;
    end else begin
      ack_len   <= ack_drv_o ? ack_len + 1 : 0;
      gap       <= tick ? 1 : gap + 1;
      seen_tick <= (state == ST_FRAME) ? (seen_tick | tick) : 1'b0;
      if (tick && seg == SEG_SOF) acked <= 1'b0;
      else if (ack_drv_o)         acked <= 1'b1;
    end
  end

  // R2
  start_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FRAME && $past(state) == ST_HUNT) |-> ($past(bus_idle) && !$past(rx_s)));

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_tick) |-> (gap == CLKS_PER_BIT));

  // R7
  ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drv_o |-> (state == ST_FRAME && (seg == SEG_ACK_SLOT || seg == SEG_ACK_DELIM)));

  // R7
  ack_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_drv_o) |-> (ack_len == CLKS_PER_BIT));

  // R8
  valid_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> acked);

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |=> !frame_valid_o);

  // R11
  valid_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> ($past(state) == ST_FRAME && state == ST_HUNT));
endmodule

bind canrx_frame canrx_chk #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .bus_idle(bus_idle), .tick(tick),
  .state(state), .seg(seg), .ack_drv_o(ack_drv_o), .frame_valid_o(frame_valid_o)
);

// File: tb/canrx_frame_test.sv
module canrx_frame_test;
  localparam int CPB  = 8;
  localparam int HALF = CPB / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_i = 1'b1;
  logic        ack_drv_o, frame_valid_o, rtr_o;
  logic [10:0] id_o;
  logic [3:0]  dlc_o;
  logic [63:0] data_o;

  canrx_frame #(.CLKS_PER_BIT(CPB), .IDLE_BITS(11), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .ack_drv_o(ack_drv_o),
    .frame_valid_o(frame_valid_o), .id_o(id_o), .rtr_o(rtr_o),
    .dlc_o(dlc_o), .data_o(data_o)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    ack_from = -1, ack_to = -2, val_at = -1;
  int    nvalid = 0, exp_nvalid = 0;
  bit    chk_on = 0;
  bit    done = 0;
  string cur_tag = "R1";

  logic [10:0] e_id = '0,  p_id = '0;
  logic        e_rtr = 0,  p_rtr = 0;
  logic [3:0]  e_dlc = '0, p_dlc = '0;
  logic [63:0] e_data = '0, p_data = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] cycle %0d: actual %h expected %h", tag, cur_tag, cyc, act, exp);
    end
  endtask

  // clock-by-clock reference comparison
  always @(negedge clk) begin
    if (chk_on) begin
      if (cyc == val_at) begin
        e_id = p_id; e_rtr = p_rtr; e_dlc = p_dlc; e_data = p_data;
      end
      if (frame_valid_o) nvalid++;
      chk("R7 ack", 64'(ack_drv_o), 64'(cyc >= ack_from && cyc <= ack_to));
      chk("R11 valid", 64'(frame_valid_o), 64'(cyc == val_at));
      chk("R11 id", 64'(id_o), 64'(e_id));
      chk("R11 rtr", 64'(rtr_o), 64'(e_rtr));
      chk("R11 dlc", 64'(dlc_o), 64'(e_dlc));
      chk("R11 data", data_o, e_data);
    end
  end

  // polynomial long division over the frame prefix
  function automatic logic [14:0] ref_crc(logic q[$]);
    logic [15:0] r = '0;
    for (int i = 0; i < q.size() + 15; i++) begin
      r = {r[14:0], (i < q.size()) ? q[i] : 1'b0};
      if (r[15]) r = r ^ 16'hC599;
    end
    return r[14:0];
  endfunction

  task automatic idle_bits(int n);
    rx_i = 1'b1;
    repeat (n * CPB) @(negedge clk);
  endtask

  task automatic run_frame(string tag, logic [10:0] id, logic rtr, logic [3:0] dlc,
                           logic [63:0] data, bit crc_bad, bit delim_dom,
                           bit eof_dom, bit started);
    logic        q[$];
    logic [14:0] c;
    int          n, ka, c0;
    bit          ack_ok, val_ok;
    cur_tag = tag;
    n = rtr ? 0 : ((dlc > 8) ? 64 : dlc * 8);
    q.push_back(1'b0);
    for (int i = 10; i >= 0; i--) q.push_back(id[i]);
    q.push_back(rtr);
    q.push_back(1'b0); q.push_back(1'b0);
    for (int i = 3; i >= 0; i--) q.push_back(dlc[i]);
    for (int i = 0; i < n; i++) q.push_back(data[63 - i]);
    c = ref_crc(q);
    if (crc_bad) c[6] = ~c[6];
    for (int i = 14; i >= 0; i--) q.push_back(c[i]);
    q.push_back(delim_dom ? 1'b0 : 1'b1);
    q.push_back(1'b1);
    q.push_back(1'b1);
    for (int i = 0; i < 7; i++) q.push_back((eof_dom && i == 3) ? 1'b0 : 1'b1);

    ack_ok = started && !crc_bad && !delim_dom;
    val_ok = ack_ok && !eof_dom;
    ka = 35 + n;
    @(negedge clk);
    c0 = cyc + 1;
    if (ack_ok) begin
      ack_from = c0 + 1 + ka * CPB;
      ack_to   = c0 + ka * CPB + CPB;
    end
    if (val_ok) begin
      val_at = c0 + 2 + (43 + n) * CPB + HALF;
      p_id = id; p_rtr = rtr; p_dlc = dlc;
      p_data = (n == 0) ? 64'h0 : (data & ~(64'hFFFF_FFFF_FFFF_FFFF >> n));
      exp_nvalid++;
    end
    for (int k = 0; k < q.size(); k++) begin
      rx_i = q[k];
      repeat (CPB) @(negedge clk);
    end
    rx_i = 1'b1;
  endtask

  task automatic do_reset();
    chk_on = 0;
    rst_n = 1'b0;
    rx_i = 1'b1;
    repeat (4) @(negedge clk);
    e_id = '0; e_rtr = 0; e_dlc = '0; e_data = '0;
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    cur_tag = "R1";
    chk("R1 ack", 64'(ack_drv_o), 64'h0);
    chk("R1 valid", 64'(frame_valid_o), 64'h0);
    chk("R1 fields", {id_o, rtr_o, dlc_o, data_o[47:0]}, 64'h0);
    chk("R1 data", data_o, 64'h0);
    chk_on = 1;
    idle_bits(12);

    run_frame("R4", 11'h2A5, 1'b0, 4'd8, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 1);
    idle_bits(14);
    run_frame("R5", 11'h011, 1'b0, 4'd0, 64'hFFFF_0000_FFFF_0000, 0, 0, 0, 1);
    idle_bits(14);
    run_frame("R11", 11'h6C1, 1'b0, 4'd3, 64'hA1B2_C3D4_E5F6_0718, 0, 0, 0, 1);
    idle_bits(14);
    run_frame("R5", 11'h345, 1'b0, 4'd12, 64'hFEDC_BA98_7654_3210, 0, 0, 0, 1);
    idle_bits(14);
    run_frame("R6", 11'h0F0, 1'b1, 4'd4, 64'h1111_2222_3333_4444, 0, 0, 0, 1);
    idle_bits(14);
    run_frame("R8", 11'h155, 1'b0, 4'd2, 64'h9C3A_0000_0000_0000, 1, 0, 0, 1);
    idle_bits(14);
    run_frame("R9", 11'h2D2, 1'b0, 4'd1, 64'h4E00_0000_0000_0000, 0, 1, 0, 1);
    idle_bits(14);
    run_frame("R10", 11'h0AB, 1'b0, 4'd2, 64'h3C5A_0000_0000_0000, 0, 0, 1, 1);
    idle_bits(14);

    // R2: a frame sent before the idle interval has elapsed is ignored
    do_reset();
    @(negedge clk);
    chk_on = 1;
    idle_bits(5);
    run_frame("R2", 11'h123, 1'b0, 4'd2, 64'h5A3C_0000_0000_0000, 0, 0, 0, 0);
    idle_bits(14);

    // R3: two-clock dominant glitch, then a good frame
    cur_tag = "R3";
    @(negedge clk);
    rx_i = 1'b0;
    repeat (2) @(negedge clk);
    rx_i = 1'b1;
    idle_bits(14);
    run_frame("R3", 11'h4C6, 1'b0, 4'd1, 64'hC300_0000_0000_0000, 0, 0, 0, 1);
    idle_bits(4);

    cur_tag = "R8";
    chk("R8 valid count", 64'(nvalid), 64'(exp_nvalid));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog [%s]: actual hung expected finished", cur_tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule